// File: doc/BRIEF.md
# Table-Driven State Machine

This block is a finite state machine whose entire combinational behaviour, both next state and outputs, is read out of one rewritable lookup table. On each clock the table word selected by the primary inputs and the current state is captured into a single register. The low part of that register drives the outputs and the high part becomes the new state, so outputs and state are always registered together.

The table is filled through a load port, one word per clock, before the machine is set running. Changing the machine's function means writing new table contents; no logic is edited. The widths of the inputs, the outputs and the state are parameters, and the table depth and word width follow from them.

Top module: `lutfsm_top`

## Requirements
- R1: The table holds 2^(IN_W+ST_W) words of OUT_W+ST_W bits; with `load_en` high at a clock edge, `load_data` is written into the word at `load_addr`.
- R2: The table address is {`in_vec`, `state`}, with `in_vec` in the upper IN_W bits and the current state in the lower ST_W bits.
- R3: A synchronous reset (`rst` high at a clock edge) clears `state` and `out_vec` to 0, and it takes priority over `load_en`.
- R4: With `rst` and `load_en` both low, each clock edge loads the addressed table word into the register: word bits [OUT_W+ST_W-1:OUT_W] become `state` and bits [OUT_W-1:0] become `out_vec`.
- R5: While `load_en` is high and `rst` is low, `state` and `out_vec` keep their values.
- R6: `out_vec` and `state` change only at a clock edge, one clock after the inputs that selected the word were sampled.
- R7: Reset does not alter the table contents; after reset the machine runs from state 0 with the words already loaded.
- R8: Rewriting the table with new contents changes the machine's behaviour with no other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vec | input | IN_W | Primary inputs of the machine |
| load_en | input | 1 | Table write enable; holds the register while high |
| load_addr | input | IN_W+ST_W | Table word written when load_en is high |
| load_data | input | OUT_W+ST_W | Word written: next state in the upper ST_W bits, outputs below |
| out_vec | output | OUT_W | Registered outputs |
| state | output | ST_W | Registered current state |

## Verification
On every cycle the assertions check that reset leaves state and outputs at zero, that a load cycle leaves the register unchanged, and that a run cycle captures exactly the word the table presented in the previous cycle. Whether that word came from the right address, whether a load actually reached the intended word, and whether reset spared the table contents can only be seen through the bench's scenarios, which compare the ports against a behavioural model holding its own copy of the table across full loads, partial rewrites, mid-run resets and a complete reprogramming.

// File: rtl/lutfsm_pkg.sv
package lutfsm_pkg;

    // What the state/output register does at the next clock edge.
    typedef enum logic [1:0] {
        REG_CAPTURE = 2'd0,
        REG_HOLD    = 2'd1,
        REG_CLEAR   = 2'd2
    } reg_mode_e;

endpackage

// File: rtl/lutfsm_ctrl.sv
module lutfsm_ctrl
    import lutfsm_pkg::*;
(
    input  logic      rst,
    input  logic      load_en,
    output reg_mode_e mode
);

    // Reset outranks loading; loading freezes the register.
    always_comb begin
        if (rst) begin
            mode = REG_CLEAR;
        end else if (load_en) begin
            mode = REG_HOLD;
        end else begin
            mode = REG_CAPTURE;
        end
    end

endmodule

// File: rtl/lutfsm_addr.sv
module lutfsm_addr #(
    parameter int IN_W = 3,
    parameter int ST_W = 3,
    localparam int AW  = IN_W + ST_W
) (
    input  logic [IN_W-1:0] in_vec,
    input  logic [ST_W-1:0] cur_state,
    output logic [AW-1:0]   rd_addr
);

    // Current state occupies the low bits, inputs the high bits.
    for (genvar gs = 0; gs < ST_W; gs++) begin : g_state_bits
        assign rd_addr[gs] = cur_state[gs];
    end

    for (genvar gi = 0; gi < IN_W; gi++) begin : g_input_bits
        assign rd_addr[ST_W+gi] = in_vec[gi];
    end

endmodule

// File: rtl/lutfsm_table.sv
module lutfsm_table #(
    parameter int AW = 6,
    parameter int WW = 7,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [WW-1:0] rd_data
);

    logic [WW-1:0] words_q [DEPTH];

    // Storage is not reset: its contents survive a machine reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    // Asynchronous read, old contents visible during a write cycle.
    always_comb begin
        rd_data = words_q[rd_addr];
    end

endmodule

// File: rtl/lutfsm_reg.sv
module lutfsm_reg
    import lutfsm_pkg::*;
#(
    parameter int OUT_W = 4,
    parameter int ST_W  = 3,
    localparam int WW   = OUT_W + ST_W
) (
    input  logic             clk,
    input  reg_mode_e        mode,
    input  logic [WW-1:0]    word_in,
    output logic [OUT_W-1:0] out_vec,
    output logic [ST_W-1:0]  state
);

    typedef struct packed {
        logic [ST_W-1:0]  nst;
        logic [OUT_W-1:0] outs;
    } word_t;

    word_t word_d, word_q;

    always_comb begin
        word_d = word_q;
        unique case (mode)
            REG_CLEAR:   word_d = '0;
            REG_HOLD:    word_d = word_q;
            REG_CAPTURE: word_d = word_t'(word_in);
            default:     word_d = word_q;
        endcase
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign out_vec = word_q.outs;
    assign state   = word_q.nst;

endmodule

// File: rtl/lutfsm_top.sv
module lutfsm_top
    import lutfsm_pkg::*;
#(
    parameter int IN_W  = 3,
    parameter int OUT_W = 4,
    parameter int ST_W  = 3,
    localparam int AW   = IN_W + ST_W,
    localparam int WW   = OUT_W + ST_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_vec,
    input  logic             load_en,
    input  logic [AW-1:0]    load_addr,
    input  logic [WW-1:0]    load_data,
    output logic [OUT_W-1:0] out_vec,
    output logic [ST_W-1:0]  state
);

    reg_mode_e     mode;
    logic [AW-1:0] rd_addr;
    logic [WW-1:0] rd_word;

    lutfsm_ctrl u_ctrl (
        .rst     (rst),
        .load_en (load_en),
        .mode    (mode)
    );

    lutfsm_addr #(
        .IN_W (IN_W),
        .ST_W (ST_W)
    ) u_addr (
        .in_vec    (in_vec),
        .cur_state (state),
        .rd_addr   (rd_addr)
    );

    lutfsm_table #(
        .AW (AW),
        .WW (WW)
    ) u_table (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    lutfsm_reg #(
        .OUT_W (OUT_W),
        .ST_W  (ST_W)
    ) u_reg (
        .clk     (clk),
        .mode    (mode),
        .word_in (rd_word),
        .out_vec (out_vec),
        .state   (state)
    );

endmodule

// File: rtl/lutfsm_chk.sv
module lutfsm_chk #(
    parameter int OUT_W = 4,
    parameter int ST_W  = 3,
    localparam int WW   = OUT_W + ST_W
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [OUT_W-1:0] out_vec,
    input logic [ST_W-1:0]  state,
    input logic [WW-1:0]    rd_word
);

    a_r3_reset_clears: assert property (@(posedge clk)
        rst |=> (state == '0) && (out_vec == '0));

    a_r5_load_holds: assert property (@(posedge clk) disable iff (rst)
        load_en |=> $stable(state) && $stable(out_vec));

    // R4 and R6: a run cycle registers the word presented one cycle earlier.
    a_r4_capture_word: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ({state, out_vec} == $past(rd_word)));

    a_r6_known_after_reset: assert property (@(posedge clk)
        rst |=> !$isunknown({state, out_vec}));

endmodule

bind lutfsm_top lutfsm_chk #(
    .OUT_W (OUT_W),
    .ST_W  (ST_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .out_vec (out_vec),
    .state   (state),
    .rd_word (rd_word)
);

// File: tb/tb_lutfsm_top.sv
module tb_lutfsm_top;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 3;
    localparam int OUT_W = 4;
    localparam int ST_W  = 3;
    localparam int AW    = IN_W + ST_W;
    localparam int WW    = OUT_W + ST_W;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IN_W-1:0]  in_vec = '0;
    logic             load_en = 1'b0;
    logic [AW-1:0]    load_addr = '0;
    logic [WW-1:0]    load_data = '0;
    logic [OUT_W-1:0] out_vec;
    logic [ST_W-1:0]  state;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural reference: its own table and register.
    int model_mem [DEPTH];
    int model_reg = 0;
    int lfsr = 32'h1d3;

    always #(CLK_PERIOD/2) clk = ~clk;

    lutfsm_top dut (
        .clk       (clk),
        .rst       (rst),
        .in_vec    (in_vec),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .out_vec   (out_vec),
        .state     (state)
    );

    always @(posedge clk) begin
        int rd;
        // R2: address is inputs above state
        rd = model_mem[(int'(in_vec) << ST_W) | (model_reg >> OUT_W)];
        if (rst)           model_reg = 0;
        else if (!load_en) model_reg = rd;
        if (load_en)       model_mem[load_addr] = int'(load_data);
    end

    function automatic int prog_a(int a);
        int i = a >> ST_W;
        int s = a & ((1 << ST_W) - 1);
        int ns = (s + i) & 7;
        int o  = (s * i + 1) & 15;
        return (ns << OUT_W) | o;
    endfunction

    function automatic int prog_b(int a);
        int i = a >> ST_W;
        int s = a & ((1 << ST_W) - 1);
        int ns = ((s << 1) | (i & 1)) & 7;
        int o  = 8 | ((i ^ s) & 7);
        return (ns << OUT_W) | o;
    endfunction

    function automatic int next_rand();
        lfsr = ((lfsr << 1) | (((lfsr >> 8) ^ (lfsr >> 4)) & 1)) & 32'h1ff;
        return lfsr;
    endfunction

    // Check at the falling edge, then set the next cycle's inputs.
    task automatic step(input int i, input bit le, input int la, input int ld,
                        input bit r, input string tag);
        @(negedge clk);
        checks++;
        if (out_vec !== OUT_W'(model_reg) || state !== ST_W'(model_reg >> OUT_W)) begin
            errors++;
            $display("FAIL %s: got out=%0h state=%0h expected out=%0h state=%0h",
                     tag, out_vec, state, model_reg & 15, model_reg >> OUT_W);
        end
        in_vec    = IN_W'(i);
        load_en   = le;
        load_addr = AW'(la);
        load_data = WW'(ld);
        rst       = r;
    endtask

    task automatic run(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            step(next_rand() & 7, 1'b0, 0, 0, 1'b0, tag);
        end
    endtask

    initial begin
        // R3: reset state, with loading during reset (reset outranks hold)
        step(0, 1'b0, 0, 0, 1'b1, "R3");
        for (int a = 0; a < DEPTH; a++) begin
            step(a & 7, 1'b1, a, prog_a(a), 1'b1, "R3");
        end
        step(0, 1'b0, 0, 0, 1'b0, "R3");
        // R2 R4 R6: run program A on varied inputs
        run(30, "R4");
        for (int c = 0; c < 8; c++) step(c, 1'b0, 0, 0, 1'b0, "R2");
        for (int c = 0; c < 6; c++) step(7, 1'b0, 0, 0, 1'b0, "R6");
        // R5 R1: partial rewrite mid-run, register must hold
        for (int a = 8; a < 24; a += 3) begin
            step(next_rand() & 7, 1'b1, a, (a * 37) & 127, 1'b0, "R5");
        end
        run(30, "R1");
        // R7: reset mid-run keeps table contents
        step(0, 1'b0, 0, 0, 1'b1, "R7");
        step(3, 1'b0, 0, 0, 1'b1, "R7");
        run(30, "R7");
        // R8: reprogram the whole table, then run
        for (int a = 0; a < DEPTH; a++) begin
            step(next_rand() & 7, 1'b1, a, prog_b(a), 1'b0, "R5");
        end
        run(40, "R8");
        step(0, 1'b0, 0, 0, 1'b0, "R8");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule